// File: doc/BRIEF.md
# Transaction-Tagged Dual-Clock FIFO

This block moves bus transactions from a producer running on one clock to a consumer running on an unrelated clock. Each stored entry carries three fields packed together: a 32-bit address or data word, a 4-bit side field for byte enables or a command, and a 4-bit tag. The tag shows where a transaction starts and ends. Tag 4'h1 (HEAD) marks the first entry of a transaction. Tag 4'h2 (TAIL) marks its final entry. Any other tag value marks a middle entry. The same block can serve either direction of a bus bridge.

The producer pushes one entry on each write-clock edge while its write strobe is high. It watches full and almost-full so that it can stop a burst in time. The consumer sees the oldest entry on its outputs at all times (show-ahead), and each read-clock edge with the read strobe high moves to the next entry. The consumer should start a transaction only after the transaction-ready flag rises, which means at least one TAIL-tagged entry has been committed and not yet consumed. A one-cycle flush pulse on the read side throws away everything stored.

Pointers and a running count of committed TAIL tags cross the clock boundary as Gray codes through two-flop synchronisers. Each side runs a small status state machine:
- Write side states: W_OPEN (more than one slot free), W_NEAR (exactly one slot free) and W_FULL (no slot free). The next state is chosen from the occupancy seen after the current edge.
- Read side states: R_EMPTY (nothing stored), R_PART (entries stored but no complete transaction) and R_TXN (at least one complete transaction stored).
- Any state can move to any other state on the next edge of its own clock.

The depth is a power of two.

Top module: `tfifo_xclk`

## Requirements
- R1: Entries leave the read side in the order they were accepted on the write side, with all 40 bits of word, side and tag intact.
- R2: While the FIFO is not empty, the read outputs show the oldest stored entry without any read strobe. Each read-clock edge with the read strobe high and empty low moves the outputs to the next entry.
- R3: Full is high once DEPTH entries are stored. A write attempted while full is dropped, and the write pointer does not move.
- R4: Almost-full is high when exactly DEPTH-1 entries are stored, so it is high on the cycle before full rises. It is never high together with full.
- R5: Empty rises on the read-clock edge that removes the last stored entry. A read attempted while empty is dropped, and the read pointer does not move.
- R6: Almost-empty is high when exactly one entry remains readable.
- R7: Transaction-ready stays low until an entry tagged TAIL (4'h2) has been committed and made visible on the read side. It is low whenever the FIFO is empty.
- R8: A one-cycle flush pulse on the read side discards all stored entries. On the next read-clock edge, empty is high and transaction-ready is low. Entries written after that are delivered normally.
- R9: After reset, empty is high, and full, almost-full, almost-empty and transaction-ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 32 | Address or data word to store |
| wr_side | input | 4 | Byte-enable or command field to store |
| wr_tag | input | 4 | Control tag (1 = HEAD, 2 = TAIL, other = middle) |
| wr_full | output | 1 | No free slot |
| wr_almost_full | output | 1 | Exactly one free slot |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read strobe (advance past the head entry) |
| rd_flush | input | 1 | Discard all stored entries |
| rd_word | output | 32 | Head entry word |
| rd_side | output | 4 | Head entry side field |
| rd_tag | output | 4 | Head entry tag |
| rd_empty | output | 1 | Nothing readable |
| rd_almost_empty | output | 1 | Exactly one entry readable |
| rd_txn_ready | output | 1 | At least one complete transaction stored |

## Verification
The block is exercised with several distinct patterns:
- A partial transaction (HEAD and a middle entry) left standing. This separates "data present" from "transaction complete" on the ready flag.
- A fill to exactly DEPTH entries followed by one extra write. This checks almost-full, full and the dropped write, which shows up as an absent word when the FIFO is drained.
- A read strobe on an empty FIFO followed by fresh writes. Here a pointer that moved would expose a wrong head entry.
- A flush of a complete transaction, followed by new data.
- A long concurrent stream with the reader stalling on a repeating pattern, with every read compared against a queue model. This shows ordering and field integrity while the pointers cross between clocks.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

    localparam int WORD_W = 32;
    localparam int SIDE_W = 4;
    localparam int TAG_W  = 4;

    localparam logic [TAG_W-1:0] TAG_HEAD = 4'h1;
    localparam logic [TAG_W-1:0] TAG_TAIL = 4'h2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [SIDE_W-1:0] side;
        logic [TAG_W-1:0]  tag;
    } entry_t;

endpackage

// File: rtl/tfifo_gray_sync.sv
// Two-flop synchroniser for a Gray-coded value, with conversion back to binary.
module tfifo_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_gray,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= src_gray;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits at or above it.
    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign dst_bin[i] = ^stage2[W-1:i];
    end

endmodule

// File: rtl/tfifo_store.sv
// Entry storage: written on the write clock, read asynchronously at the head address.
module tfifo_store
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [AW-1:0] raddr,
    output entry_t        rdata
);

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tfifo_wr_ctrl.sv
// Write-side pointer, TAIL counter and status state machine.
module tfifo_wr_ctrl
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] tag_in,
    input  logic [PW-1:0]    rptr_sync,
    output logic [PW-1:0]    wptr_gray,
    output logic [PW-1:0]    tail_gray,
    output logic             mem_we,
    output logic [PW-2:0]    mem_waddr,
    output logic             full,
    output logic             almost_full
);

    typedef enum logic [1:0] {
        W_OPEN,
        W_NEAR,
        W_FULL
    } wstate_t;

    wstate_t       state, state_nx;
    logic [PW-1:0] wptr, wptr_nx;
    logic [PW-1:0] tails, tails_nx;
    logic [PW-1:0] level_nx;
    logic [PW-1:0] level_now;
    logic          accept;

    assign accept    = wr_en && (state != W_FULL);
    assign wptr_nx   = wptr + PW'(accept);
    assign tails_nx  = tails + PW'(accept && (tag_in == TAG_TAIL));
    assign level_nx  = wptr_nx - rptr_sync;
    assign level_now = wptr - rptr_sync;

    always_comb begin
        if (level_nx == PW'(DEPTH)) begin
            state_nx = W_FULL;
        end else if (level_nx == PW'(DEPTH - 1)) begin
            state_nx = W_NEAR;
        end else begin
            state_nx = W_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= W_OPEN;
            wptr      <= '0;
            wptr_gray <= '0;
            tails     <= '0;
            tail_gray <= '0;
        end else begin
            state     <= state_nx;
            wptr      <= wptr_nx;
            wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
            tails     <= tails_nx;
            tail_gray <= tails_nx ^ (tails_nx >> 1);
        end
    end

    always_comb begin
        full        = 1'b0;
        almost_full = 1'b0;
        unique case (state)
            W_OPEN: ;
            W_NEAR: almost_full = 1'b1;
            W_FULL: full        = 1'b1;
            default: ;
        endcase
    end

    assign mem_we    = accept;
    assign mem_waddr = wptr[PW-2:0];

    // R3: a write while full leaves the write pointer where it was
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> (wptr == $past(wptr)));

    // R3: stored count never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level_now <= PW'(DEPTH));

    // R4: full is only reached from the one-slot-left condition
    a_r4_near_before_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(almost_full));

endmodule

// File: rtl/tfifo_rd_ctrl.sv
// Read-side pointer, consumed-TAIL counter, flush and status state machine.
module tfifo_rd_ctrl
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             flush,
    input  logic [TAG_W-1:0] head_tag,
    input  logic [PW-1:0]    wptr_sync,
    input  logic [PW-1:0]    tail_sync,
    output logic [PW-1:0]    rptr_gray,
    output logic [PW-2:0]    mem_raddr,
    output logic             empty,
    output logic             almost_empty,
    output logic             txn_ready
);

    typedef enum logic [1:0] {
        R_EMPTY,
        R_PART,
        R_TXN
    } rstate_t;

    rstate_t       state, state_nx;
    logic [PW-1:0] rptr, rptr_nx;
    logic [PW-1:0] used, used_nx;
    logic [PW-1:0] level_nx;
    logic [PW-1:0] txn_nx;
    logic [PW-1:0] level_now;
    logic          accept;
    logic          ae_q;

    assign accept = rd_en && !flush && (state != R_EMPTY);

    always_comb begin
        if (flush) begin
            rptr_nx = wptr_sync;
            used_nx = tail_sync;
        end else begin
            rptr_nx = rptr + PW'(accept);
            used_nx = used + PW'(accept && (head_tag == TAG_TAIL));
        end
    end

    assign level_nx  = wptr_sync - rptr_nx;
    assign txn_nx    = tail_sync - used_nx;
    assign level_now = wptr_sync - rptr;

    always_comb begin
        if (level_nx == '0) begin
            state_nx = R_EMPTY;
        end else if (txn_nx != '0) begin
            state_nx = R_TXN;
        end else begin
            state_nx = R_PART;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= R_EMPTY;
            rptr      <= '0;
            rptr_gray <= '0;
            used      <= '0;
            ae_q      <= 1'b0;
        end else begin
            state     <= state_nx;
            rptr      <= rptr_nx;
            rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
            used      <= used_nx;
            ae_q      <= (level_nx == PW'(1));
        end
    end

    always_comb begin
        empty        = 1'b0;
        txn_ready    = 1'b0;
        almost_empty = ae_q;
        unique case (state)
            R_EMPTY: empty     = 1'b1;
            R_PART:  ;
            R_TXN:   txn_ready = 1'b1;
            default: ;
        endcase
    end

    assign mem_raddr = rptr[PW-2:0];

    // R5: a read while empty leaves the read pointer where it was
    a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !flush) |=> (rptr == $past(rptr)));

    // R8: flush moves the read pointer onto the synchronised write pointer
    a_r8_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rptr == $past(wptr_sync)));

    // R1: the read pointer never runs past the visible write pointer
    a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        level_now <= PW'(DEPTH));

endmodule

// File: rtl/tfifo_xclk.sv
module tfifo_xclk
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [SIDE_W-1:0] wr_side,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              wr_full,
    output logic              wr_almost_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              rd_flush,
    output logic [WORD_W-1:0] rd_word,
    output logic [SIDE_W-1:0] rd_side,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_empty,
    output logic              rd_almost_empty,
    output logic              rd_txn_ready
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr_gray, tail_gray, rptr_gray;
    logic [PW-1:0] wptr_at_rd, tail_at_rd, rptr_at_wr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    entry_t        wdata, rdata;

    assign wdata = '{word: wr_word, side: wr_side, tag: wr_tag};

    tfifo_wr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .wr_en       (wr_en),
        .tag_in      (wr_tag),
        .rptr_sync   (rptr_at_wr),
        .wptr_gray   (wptr_gray),
        .tail_gray   (tail_gray),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .full        (wr_full),
        .almost_full (wr_almost_full)
    );

    tfifo_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wdata),
        .raddr (mem_raddr),
        .rdata (rdata)
    );

    tfifo_gray_sync #(.W(PW)) u_sync_wptr (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .src_gray (wptr_gray),
        .dst_bin  (wptr_at_rd)
    );

    tfifo_gray_sync #(.W(PW)) u_sync_tail (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .src_gray (tail_gray),
        .dst_bin  (tail_at_rd)
    );

    tfifo_gray_sync #(.W(PW)) u_sync_rptr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .src_gray (rptr_gray),
        .dst_bin  (rptr_at_wr)
    );

    tfifo_rd_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .rd_en        (rd_en),
        .flush        (rd_flush),
        .head_tag     (rdata.tag),
        .wptr_sync    (wptr_at_rd),
        .tail_sync    (tail_at_rd),
        .rptr_gray    (rptr_gray),
        .mem_raddr    (mem_raddr),
        .empty        (rd_empty),
        .almost_empty (rd_almost_empty),
        .txn_ready    (rd_txn_ready)
    );

    assign rd_word = rdata.word;
    assign rd_side = rdata.side;
    assign rd_tag  = rdata.tag;

endmodule

// File: tb/tfifo_xclk_tb.sv
module tfifo_xclk_tb;

    localparam int  DEPTH   = 16;
    localparam time WCLK_T  = 10;
    localparam time RCLK_T  = 14;
    localparam int  STREAM_N = 120;

    logic        wr_clk = 0, rd_clk = 0;
    logic        wr_rst_n = 0, rd_rst_n = 0;
    logic        wr_en = 0, rd_en = 0, rd_flush = 0;
    logic [31:0] wr_word = '0;
    logic [3:0]  wr_side = '0, wr_tag = '0;
    logic        wr_full, wr_almost_full;
    logic [31:0] rd_word;
    logic [3:0]  rd_side, rd_tag;
    logic        rd_empty, rd_almost_empty, rd_txn_ready;

    int checks = 0;
    int fails  = 0;
    logic [39:0] model[$];
    bit last_full, last_af, last_empty, last_ae;
    bit done = 0;

    always #(WCLK_T/2) wr_clk = ~wr_clk;
    always #(RCLK_T/2) rd_clk = ~rd_clk;

    tfifo_xclk #(.DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en),
        .wr_word(wr_word), .wr_side(wr_side), .wr_tag(wr_tag),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_flush(rd_flush),
        .rd_word(rd_word), .rd_side(rd_side), .rd_tag(rd_tag),
        .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty),
        .rd_txn_ready(rd_txn_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write attempt; flags sampled at the negedge before the edge.
    task automatic wr_push(input logic [31:0] w, input logic [3:0] s, input logic [3:0] t);
        @(negedge wr_clk);
        last_full = wr_full;
        last_af   = wr_almost_full;
        wr_en   = 1;
        wr_word = w;
        wr_side = s;
        wr_tag  = t;
        @(posedge wr_clk);
        if (!last_full) model.push_back({w, s, t});
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    // One read cycle; if en and not empty, head is compared with the model (R1, R2).
    task automatic rd_cycle(input bit en);
        logic [39:0] act;
        bit take;
        @(negedge rd_clk);
        last_empty = rd_empty;
        last_ae    = rd_almost_empty;
        rd_en = en;
        take  = en && !last_empty;
        if (take) begin
            act = {rd_word, rd_side, rd_tag};
            if (model.size() == 0) chk(0, "R1 read with empty model", act, 0);
            else chk(act == model[0], "R1 order/fields", act, model[0]);
        end
        @(posedge rd_clk);
        if (take && model.size() != 0) void'(model.pop_front());
    endtask

    task automatic settle();
        repeat (10) @(negedge rd_clk);
        rd_en = 0;
    endtask

    initial begin
        #(WCLK_T * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge rd_clk);
        wr_rst_n = 1;
        rd_rst_n = 1;
        @(negedge rd_clk);
        // R9 reset state
        chk(rd_empty == 1, "R9 empty", rd_empty, 1);
        chk(rd_almost_empty == 0, "R9 almost_empty", rd_almost_empty, 0);
        chk(rd_txn_ready == 0, "R9 txn_ready", rd_txn_ready, 0);
        chk(wr_full == 0, "R9 full", wr_full, 0);
        chk(wr_almost_full == 0, "R9 almost_full", wr_almost_full, 0);

        // R7: partial transaction is not ready
        wr_push(32'hA000_0000, 4'h3, 4'h1);
        wr_push(32'hA000_0001, 4'h4, 4'h7);
        wr_idle();
        settle();
        chk(rd_txn_ready == 0, "R7 no tail yet", rd_txn_ready, 0);
        chk(rd_empty == 0, "R5 data visible", rd_empty, 0);
        chk({rd_word, rd_side, rd_tag} == model[0], "R2 show-ahead head", {rd_word, rd_side, rd_tag}, model[0]);
        wr_push(32'hA000_0002, 4'h5, 4'h2);
        wr_idle();
        settle();
        chk(rd_txn_ready == 1, "R7 tail committed", rd_txn_ready, 1);
        chk(rd_almost_empty == 0, "R6 three stored", rd_almost_empty, 0);

        // R1/R6/R5 drain
        rd_cycle(1);
        rd_cycle(1);
        rd_cycle(1);
        chk(last_ae == 1, "R6 one left", last_ae, 1);
        rd_cycle(0);
        chk(last_empty == 1, "R5 empty after last", last_empty, 1);
        chk(rd_txn_ready == 0, "R7 ready low when empty", rd_txn_ready, 0);

        // R5: read while empty ignored
        rd_cycle(1);
        rd_cycle(0);
        chk(last_empty == 1, "R5 still empty", last_empty, 1);
        wr_push(32'hB000_0000, 4'h1, 4'h1);
        wr_push(32'hB000_0001, 4'h2, 4'h2);
        wr_idle();
        settle();
        chk(rd_word == 32'hB000_0000, "R5 pointer unmoved", rd_word, 32'hB000_0000);
        rd_cycle(1);
        rd_cycle(1);
        rd_cycle(0);
        settle();

        // R3/R4 fill
        for (int i = 0; i < DEPTH; i++) begin
            wr_push(32'hC000_0000 + i, 4'(i), (i == DEPTH-1) ? 4'h2 : 4'h9);
            if (i == DEPTH-1) begin
                chk(last_af == 1, "R4 almost_full at DEPTH-1", last_af, 1);
                chk(last_full == 0, "R4 not full at DEPTH-1", last_full, 0);
            end
        end
        wr_push(32'hDEAD_BEEF, 4'hF, 4'h2);
        chk(last_full == 1, "R3 full at DEPTH", last_full, 1);
        chk(last_af == 0, "R4 exclusive with full", last_af, 0);
        wr_idle();
        chk(wr_full == 1, "R3 still full", wr_full, 1);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            rd_cycle(1);
            if (i == DEPTH-1) chk(last_ae == 1, "R6 last of fill", last_ae, 1);
        end
        rd_cycle(0);
        chk(last_empty == 1, "R3 extra write dropped", last_empty, 1);
        settle();

        // R8 flush
        wr_push(32'hE000_0000, 4'h1, 4'h1);
        wr_push(32'hE000_0001, 4'h2, 4'h5);
        wr_push(32'hE000_0002, 4'h3, 4'h2);
        wr_idle();
        settle();
        chk(rd_txn_ready == 1, "R7 before flush", rd_txn_ready, 1);
        @(negedge rd_clk);
        rd_flush = 1;
        @(negedge rd_clk);
        rd_flush = 0;
        model.delete();
        chk(rd_empty == 1, "R8 empty after flush", rd_empty, 1);
        chk(rd_txn_ready == 0, "R8 ready low after flush", rd_txn_ready, 0);
        wr_push(32'hF000_0000, 4'h6, 4'h1);
        wr_push(32'hF000_0001, 4'h7, 4'h2);
        wr_idle();
        settle();
        rd_cycle(1);
        rd_cycle(1);
        rd_cycle(0);
        chk(last_empty == 1, "R8 only new data", last_empty, 1);
        settle();

        // R1 concurrent stream
        fork
            begin
                for (int i = 0; i < STREAM_N; i++) begin
                    bit ok = 0;
                    while (!ok) begin
                        wr_push(32'h5000_0000 + i, 4'(i * 3), (i % 5 == 4) ? 4'h2 : ((i % 5 == 0) ? 4'h1 : 4'h3));
                        ok = !last_full;
                    end
                end
                wr_idle();
                done = 1;
            end
            begin
                int k = 0;
                while (!(done && model.size() == 0)) begin
                    rd_cycle(k % 3 != 0);
                    k++;
                end
                rd_cycle(0);
            end
        join
        settle();
        chk(rd_empty == 1, "R5 stream drained", rd_empty, 1);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule